// File: doc/BRIEF.md
# Video Capture Window Start Controller

This block decides the cycle in which capture of the first field begins. A two-bit mode input selects one of three start rules. In the two line-based modes the block counts pixels and lines of the incoming image, before any scaling, and starts capture at a programmed line and pixel position. In raw mode it measures how long the capture-enable input stays low to find vertical blanking. It can hold off the first capture until two blanking intervals have passed, so that capture begins at the top of a frame. In transport-stream mode it starts on a sync byte while capture enable is high and the frame-complete flag is clear.

Software programs one 32-bit start register through a simple write port and can read it back. The block's only result is the `cap_active` flag. Once this flag rises, it stays high until the current field or burst ends.

Top module: `vcap_start_ctrl`

## Requirements
- R1: The start register reads as {4'b0, line_start[11:0], sync_wait, 3'b0, low_field[11:0]}. Line_start sits at bits 27:16, sync_wait at bit 15 and low_field at bits 11:0. Reset gives 0x0000_8000. A write takes effect on the next cycle. Bits 31:28 and 14:12 always read as zero.
- R2: Modes 0 and 1 are line-based. A horizontal event sets the pixel counter to 0, and the pixel counter otherwise counts up by one each clock. A vertical event sets the line counter to 1, and each later horizontal event adds one to it. `cap_active` rises the cycle after the counters first show line == line_start and pixel >= low_field.
- R3: In the line-based modes a vertical event clears `cap_active`. Between vertical events it stays high once set. It never rises while `f1_en` is low. A line_start of 0 never matches.
- R4: In raw mode (mode 2) a blanking interval is recorded on the clock where `cap_in` has been sampled low for more than low_field consecutive clocks. A low run of exactly low_field clocks records nothing. A recorded interval clears `cap_active`.
- R5: In raw mode with sync_wait clear, `cap_active` rises on the clock after `cap_in` is sampled high. `chan_en` must have been high on the clock before.
- R6: In raw mode, if sync_wait is 1 when `chan_en` rises, no capture starts until two blanking intervals have been recorded. Later captures under the same enable do not wait.
- R7: In transport-stream mode (mode 3) `cap_active` rises on the clock after `din` equals 0x47 while `cap_in` is high and `frm_done` is low. Every other byte value leaves it low.
- R8: In transport-stream mode a high `frm_done` blocks the start. A low `cap_in` clears `cap_active`, and `din` has no effect once capture is active.
- R9: A low `chan_en` clears `cap_active` on the next clock and discards any pending two-interval wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0/1 line-based, 2 raw, 3 transport stream |
| chan_en | input | 1 | Channel capture enable |
| f1_en | input | 1 | Field 1 capture enable |
| cap_in | input | 1 | External capture-enable signal |
| h_evt | input | 1 | Horizontal event pulse |
| v_evt | input | 1 | Vertical event pulse |
| din | input | DW | Incoming data word |
| frm_done | input | 1 | Frame-complete status flag |
| wr_en | input | 1 | Start register write strobe |
| wr_data | input | 32 | Start register write data |
| rd_data | output | 32 | Start register read value |
| cap_active | output | 1 | Capture in progress |

## Verification
The assertions check several rules on every cycle:
- a write is reflected with the reserved bits masked off;
- a low `chan_en`, a vertical event in the line modes, or a low `cap_in` in transport-stream mode always leaves capture inactive on the next clock;
- no capture begins while `f1_en` is low, while `cap_in` is low in raw mode, or without a sync byte in transport-stream mode.

Only the bench scenarios can show the exact start cycle for each line and pixel setting, the boundary between a low run of low_field clocks and one of low_field+1 clocks, the two-interval hold-off and its release, and that exactly one of the 256 byte values starts a stream capture.

// File: rtl/vcap_start_ctrl.sv
module vcap_start_ctrl #(
  parameter int DW = 8,
  parameter logic [DW-1:0] SYNC_BYTE = 8'h47
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          chan_en,
  input  logic          f1_en,
  input  logic          cap_in,
  input  logic          h_evt,
  input  logic          v_evt,
  input  logic [DW-1:0] din,
  input  logic          frm_done,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  output logic [31:0]   rd_data,
  output logic          cap_active
);
  localparam int CW = 12;
  localparam int BW = CW + 1;
  localparam logic [1:0] M_RAW = 2'd2;
  localparam logic [1:0] M_TS  = 2'd3;
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [BW-1:0] BMAX = '1;

  logic [CW-1:0] line_start, low_field;
  logic          sync_wait;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_start <= '0;
      low_field  <= '0;
      sync_wait  <= 1'b1;
    end else if (wr_en) begin
      line_start <= wr_data[27:16];
      sync_wait  <= wr_data[15];
      low_field  <= wr_data[11:0];
    end
  end

  assign rd_data = {4'b0, line_start, sync_wait, 3'b0, low_field};

  logic [CW-1:0] pix, line;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix  <= '0;
      line <= CW'(1);
    end else begin
      if (h_evt) pix <= '0;
      else if (pix != CMAX) pix <= pix + 1'b1;
      if (v_evt) line <= CW'(1);
      else if (h_evt && line != CMAX) line <= line + 1'b1;
    end
  end

  logic [BW-1:0] blank;
  always_ff @(posedge clk) begin
    if (!rst_n || cap_in) blank <= '0;
    else if (blank != BMAX) blank <= blank + 1'b1;
  end

  wire blank_hit = (mode == M_RAW) && !cap_in && (blank == {1'b0, low_field});

  logic       chan_q;
  logic [1:0] waits;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_q <= 1'b0;
      waits  <= '0;
    end else begin
      chan_q <= chan_en;
      if (!chan_en) waits <= '0;
      else if (!chan_q) waits <= sync_wait ? 2'd2 : 2'd0;
      else if (blank_hit && waits != 2'd0) waits <= waits - 1'b1;
    end
  end

  logic go, stop;
  always_comb begin
    go   = 1'b0;
    stop = 1'b0;
    case (mode)
      M_RAW: begin
        go   = cap_in && chan_q && waits == 2'd0;
        stop = blank_hit;
      end
      M_TS: begin
        go   = cap_in && !frm_done && din == SYNC_BYTE;
        stop = !cap_in;
      end
      default: begin
        go   = line == line_start && pix >= low_field;
        stop = v_evt;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !chan_en || stop) cap_active <= 1'b0;
    else if (go && f1_en) cap_active <= 1'b1;
  end
endmodule

module vcap_start_ctrl_chk #(
  parameter int DW = 8,
  parameter logic [DW-1:0] SYNC_BYTE = 8'h47
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic          chan_en,
  input logic          f1_en,
  input logic          cap_in,
  input logic          v_evt,
  input logic [DW-1:0] din,
  input logic          frm_done,
  input logic          wr_en,
  input logic [31:0]   wr_data,
  input logic [31:0]   rd_data,
  input logic          cap_active
);
  assert_write_masked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == ($past(wr_data) & 32'h0FFF_8FFF));

  assert_vevt_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[1] && v_evt) |=> !cap_active);

  assert_no_f1_no_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!f1_en && !cap_active) |=> !cap_active);

  assert_raw_needs_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !cap_in && !cap_active) |=> !cap_active);

  assert_ts_needs_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !cap_active && !(cap_in && !frm_done && din == SYNC_BYTE)) |=> !cap_active);

  assert_ts_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !cap_in) |=> !cap_active);

  assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> !cap_active);
endmodule

bind vcap_start_ctrl vcap_start_ctrl_chk #(.DW(DW), .SYNC_BYTE(SYNC_BYTE)) u_chk (.*);

// File: tb/tb_vcap_start_ctrl.sv
module tb_vcap_start_ctrl;
  localparam int LEN = 6;
  localparam int LIMIT = 4 * LEN;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic chan_en = 1'b0, f1_en = 1'b1, cap_in = 1'b0, h_evt = 1'b0, v_evt = 1'b0;
  logic [7:0] din = 8'd0;
  logic frm_done = 1'b0, wr_en = 1'b0;
  logic [31:0] wr_data = 32'd0;
  logic [31:0] rd_data;
  logic cap_active;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vcap_start_ctrl dut (.*);

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    wr_en = 1'b1; wr_data = v; step(); wr_en = 1'b0;
  endtask

  task automatic raw_hold(input logic lvl, input int n, input logic exp, input string tag);
    cap_in = lvl;
    for (int i = 0; i < n; i++) begin
      step();
      check(tag, cap_active, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog: actual=timeout expected=done");
      report();
    end
  end

  initial begin
    int first, cnt, exp;
    @(negedge clk); step(); step();
    rst_n = 1'b1; step();
    check("R1 reset value", rd_data, 32'h0000_8000);
    check("R9 reset inactive", {31'd0, cap_active}, 32'd0);
    wr(32'hFFFF_FFFF);
    check("R1 reserved bits zero", rd_data, 32'h0FFF_8FFF);
    wr(32'h0123_4567);
    check("R1 field layout", rd_data, 32'h0123_0567);

    chan_en = 1'b1;
    for (int m = 0; m < 2; m++)
      for (int vs = 0; vs < 4; vs++)
        for (int hs = 0; hs <= LEN; hs++) begin
          mode = 2'(m);
          wr({4'd0, 12'(vs), 4'd0, 12'(hs)});
          v_evt = 1'b1; h_evt = 1'b1; step(); v_evt = 1'b0; h_evt = 1'b0;
          check("R3 vertical event clears", {31'd0, cap_active}, 32'd0);
          first = 0; cnt = 0;
          for (int t = 1; t <= LIMIT; t++) begin
            h_evt = (t % LEN == 0);
            step();
            if (cap_active) begin cnt++; if (first == 0) first = t; end
          end
          h_evt = 1'b0;
          exp = (vs >= 1 && hs < LEN) ? (vs - 1) * LEN + hs + 1 : 0;
          check("R2 start cycle", 32'(first), 32'(exp));
          check("R3 held until vertical event", 32'(cnt), 32'(exp != 0 ? LIMIT - exp + 1 : 0));
        end

    f1_en = 1'b0; wr({4'd0, 12'd1, 4'd0, 12'd2});
    v_evt = 1'b1; h_evt = 1'b1; step(); v_evt = 1'b0; h_evt = 1'b0;
    cnt = 0;
    for (int t = 1; t <= LIMIT; t++) begin h_evt = (t % LEN == 0); step(); if (cap_active) cnt++; end
    h_evt = 1'b0;
    check("R3 field1 disabled never starts", 32'(cnt), 32'd0);
    f1_en = 1'b1;

    mode = 2'd2; chan_en = 1'b0; cap_in = 1'b0;
    wr({4'd0, 12'd0, 4'b1000, 12'd3});
    step(); chan_en = 1'b1; step(); step();
    raw_hold(1'b1, 4, 1'b0, "R6 wait before intervals");
    raw_hold(1'b0, 3, 1'b0, "R4 low run of N not interval");
    raw_hold(1'b1, 3, 1'b0, "R6 still waiting");
    raw_hold(1'b0, 4, 1'b0, "R6 first interval");
    raw_hold(1'b1, 3, 1'b0, "R6 one interval not enough");
    raw_hold(1'b0, 4, 1'b0, "R6 second interval");
    raw_hold(1'b1, 1, 1'b1, "R6 start after two intervals");
    raw_hold(1'b0, 3, 1'b1, "R4 short low keeps capture");
    raw_hold(1'b0, 1, 1'b0, "R4 interval ends capture");
    raw_hold(1'b1, 1, 1'b1, "R6 later capture no wait");
    chan_en = 1'b0; step();
    check("R9 disable clears", {31'd0, cap_active}, 32'd0);
    chan_en = 1'b1; step(); step();
    raw_hold(1'b1, 3, 1'b0, "R9 re-enable waits again");
    chan_en = 1'b0; cap_in = 1'b0; step();
    wr({4'd0, 12'd0, 4'b0000, 12'd3});
    chan_en = 1'b1; step(); step();
    raw_hold(1'b1, 1, 1'b1, "R5 immediate start without sync wait");

    mode = 2'd3; cap_in = 1'b0; step();
    for (int b = 0; b < 256; b++) begin
      cap_in = 1'b1; frm_done = 1'b0; din = 8'(b); step();
      check("R7 sync byte sweep", {31'd0, cap_active}, {31'd0, b == 8'h47});
      cap_in = 1'b0; din = 8'd0; step();
      check("R8 cap low ends", {31'd0, cap_active}, 32'd0);
    end
    cap_in = 1'b1; frm_done = 1'b1; din = 8'h47; step();
    check("R8 frame done blocks", {31'd0, cap_active}, 32'd0);
    frm_done = 1'b0; f1_en = 1'b0; step();
    check("R7 field1 disabled blocks", {31'd0, cap_active}, 32'd0);
    f1_en = 1'b1; step();
    check("R7 start", {31'd0, cap_active}, 32'd1);
    din = 8'h00; step(); step();
    check("R8 data ignored once active", {31'd0, cap_active}, 32'd1);

    done = 1'b1;
    report();
  end
endmodule